// File: doc/BRIEF.md
# Power Supervisor Reset Sequencer

This block handles the digital side of supply monitoring for a small microcontroller. Two comparator flags come in from the analog side: one says the supply is below the reset threshold, the other says it is below the higher warning threshold. Both flags are asynchronous to the block clock, so each passes through a two-flop synchronizer before any logic uses it.

While the supply is below the reset threshold, the block keeps the oscillator disabled and holds the core in reset. Software plays no part in this. When the supply recovers, the block enables the oscillator first. It then counts a fixed number of clocks to let the oscillator settle, and only after that count does it release the core reset. If the supply dips at any point, during the count or after release, the block returns to the hold state at once. After such a dip, the count starts again from zero.

The warning comparator drives a status flag at all times. It also drives an early power-fail interrupt request, but only when software has set an enable bit. That bit is bit 5 of a control register at address 0xD8. The request is a level: it stays high for as long as both the condition and the enable hold. The request carries a fixed vector of 0x0033 and has the highest priority among interrupt sources. The enable bit is forced to zero while the core is in reset.

Top module: `pwr_supervisor`

## Requirements
- R1: While rst_ni is low, osc_en_o is 0, core_rst_o is 1 and pf_irq_o is 0.
- R2: Both comparator inputs pass through two flops. An input change first shows on pf_warn_o after the second rising edge. It first shows on osc_en_o and core_rst_o after the third rising edge.
- R3: While the synchronized low_rst flag is 1, osc_en_o stays 0 and core_rst_o stays 1.
- R4: After low_rst_i falls, osc_en_o rises after the third rising edge. core_rst_o falls exactly SETTLE_CYCLES rising edges later (default 65536).
- R5: If low_rst_i rises during the settle count, the oscillator is turned off and the count is dropped. After recovery, the full SETTLE_CYCLES count is needed again.
- R6: If low_rst_i rises after release, core_rst_o returns to 1 and osc_en_o returns to 0 after the third rising edge.
- R7: A write with reg_we_i=1 and reg_addr_i=0xD8 loads the interrupt enable from reg_wdata_i[5]. A write to any other address leaves the enable unchanged.
- R8: pf_irq_o is 1 exactly when the enable is 1 and the synchronized warning flag is 1. It is a level and has no latching.
- R9: pf_warn_o shows the synchronized warning flag whatever the enable setting.
- R10: While core_rst_o is 1, the enable is held at 0 and writes have no effect.
- R11: pf_vec_o always reads 0x0033.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| low_rst_i | input | 1 | Async flag: supply below reset threshold |
| low_warn_i | input | 1 | Async flag: supply below warning threshold |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Core reset, active high |
| pf_irq_o | output | 1 | Power-fail interrupt request, level |
| pf_warn_o | output | 1 | Synchronized warning status |
| pf_vec_o | output | 16 | Power-fail interrupt vector address |

## Verification
On every cycle, the assertions check the following:
- The oscillator is never off while the core is out of reset.
- A synchronized supply-low flag always leads to the hold state.
- The oscillator always rises with a zeroed count.
- Reset is only ever released from the last count value.
- The enable is cleared throughout reset.

Some behaviour only the bench scenarios can show:
- The exact edge counts from a comparator change to each output.
- A dip in mid-count forcing a full second count.
- Enable writes to the right and wrong addresses under random warning patterns.
- A write made during reset being lost.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned        WIDTH   = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_rst_i,
  output logic osc_en_o,
  output logic core_rst_o
);
  localparam int unsigned CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_HOLD: begin
        cnt_d = '0;
        if (!low_rst_i) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (low_rst_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: begin
        cnt_d = '0;
        if (low_rst_i) state_d = ST_HOLD;
      end
      default: begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign osc_en_o   = (state_q != ST_HOLD);
  assign core_rst_o = (state_q != ST_RUN);

  AST_LOW_FORCES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_rst_i |=> (!osc_en_o && core_rst_o)); // R3
  AST_OSC_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> core_rst_o); // R3
  AST_COUNT_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> (cnt_q == '0)); // R5
  AST_RELEASE_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> ($past(cnt_q) == CNT_LAST && $past(osc_en_o))); // R4
endmodule

// File: rtl/pwr_pfi.sv
module pwr_pfi #(
  parameter logic [7:0] CTRL_ADDR = 8'hD8,
  parameter int unsigned EN_BIT   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       core_rst_i,
  input  logic       warn_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic       irq_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    en_q <= 1'b0;
    else if (core_rst_i)                            en_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == CTRL_ADDR)   en_q <= reg_wdata_i[EN_BIT];
  end

  assign irq_o = en_q & warn_i;

  AST_EN_CLEAR_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_i |=> !en_q); // R10
  AST_NO_IRQ_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_i && $past(core_rst_i)) |-> !irq_o); // R10
  AST_IRQ_NEEDS_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warn_i |-> !irq_o); // R8
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int unsigned SETTLE_CYCLES = 65536,
  parameter logic [7:0]  CTRL_ADDR     = 8'hD8,
  parameter int unsigned EN_BIT        = 5,
  parameter logic [15:0] PF_VECTOR     = 16'h0033
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        low_rst_i,
  input  logic        low_warn_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic        osc_en_o,
  output logic        core_rst_o,
  output logic        pf_irq_o,
  output logic        pf_warn_o,
  output logic [15:0] pf_vec_o
);
  logic [1:0] flags_s;

  pwr_sync #(.WIDTH(2), .RST_VAL(2'b11)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({low_warn_i, low_rst_i}),
    .q_o    (flags_s)
  );

  pwr_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .low_rst_i  (flags_s[0]),
    .osc_en_o   (osc_en_o),
    .core_rst_o (core_rst_o)
  );

  pwr_pfi #(.CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)) i_pfi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_rst_i  (core_rst_o),
    .warn_i      (flags_s[1]),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (pf_irq_o)
  );

  assign pf_warn_o = flags_s[1];
  assign pf_vec_o  = PF_VECTOR;

  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_irq_o |-> pf_warn_o); // R9
endmodule

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;
  localparam int unsigned N = 65536;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        low_rst = 1'b1, low_warn = 1'b1, we = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        osc_en, core_rst, irq, warn_flag;
  logic [15:0] vec;

  int total = 0, bad = 0;
  logic w1 = 1'b1, w2 = 1'b1, en_m = 1'b0;

  always #10 clk = ~clk;

  pwr_supervisor i_pwr_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .low_rst_i(low_rst), .low_warn_i(low_warn),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .osc_en_o(osc_en), .core_rst_o(core_rst), .pf_irq_o(irq),
    .pf_warn_o(warn_flag), .pf_vec_o(vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one edge; model warn sync and enable; return at negedge
  task automatic tick();
    @(posedge clk);
    if (core_rst) en_m = 1'b0;
    else if (we && addr == 8'hD8) en_m = wdata[5];
    w2 = w1;
    w1 = low_warn;
    @(negedge clk);
  endtask

  function automatic logic exp_irq(input logic en, input logic w);
    return en & w;
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #35;
    check("R1 osc", osc_en, 0);
    check("R1 rst", core_rst, 1);
    check("R1 irq", irq, 0);
    check("R11 vec", vec, 16'h0033);
    @(negedge clk);
    rst_ni = 1'b1;
    // supply low: hold, and attempt enable write during reset
    we = 1'b1; addr = 8'hD8; wdata = 8'h20;
    ticks(20);
    we = 1'b0;
    check("R3 osc low", osc_en, 0);
    check("R3 rst low", core_rst, 1);
    // recovery, then dip during settle
    low_rst = 1'b0;
    ticks(2);
    check("R2 osc after 2 edges", osc_en, 0);
    tick();
    check("R4 osc after 3 edges", osc_en, 1);
    check("R4 rst during settle", core_rst, 1);
    ticks(100);
    low_rst = 1'b1;
    ticks(2);
    check("R5 osc still on", osc_en, 1);
    tick();
    check("R5 osc off after dip", osc_en, 0);
    check("R5 rst after dip", core_rst, 1);
    ticks(5);
    low_rst = 1'b0;
    ticks(3);
    check("R5 osc restart", osc_en, 1);
    ticks(N - 1);
    check("R5 full count needed", core_rst, 1);
    tick();
    check("R4 released", core_rst, 0);
    check("R10 enable lost", irq, 0);
    check("R9 flag with en off", warn_flag, 1);
    // random phase in run
    for (int i = 0; i < 400; i++) begin
      low_warn = 1'($urandom);
      we = ($urandom % 3) == 0;
      addr = (($urandom % 2) == 0) ? 8'hD8 : 8'($urandom);
      wdata = 8'($urandom);
      tick();
      check((addr == 8'hD8) ? "R7 R8 irq" : "R7 other addr irq", irq, exp_irq(en_m, w2));
      check("R9 flag", warn_flag, w2);
    end
    // directed: enable on, warn on
    we = 1'b1; addr = 8'hD8; wdata = 8'h20; low_warn = 1'b1;
    tick(); we = 1'b0;
    ticks(2);
    check("R8 irq level", irq, 1);
    ticks(10);
    check("R8 irq held", irq, 1);
    we = 1'b1; addr = 8'hD9; wdata = 8'h00;
    tick(); we = 1'b0;
    check("R7 wrong addr keeps en", irq, 1);
    // drop after release
    low_rst = 1'b1;
    ticks(2);
    check("R6 rst still off", core_rst, 0);
    tick();
    check("R6 rst back", core_rst, 1);
    check("R6 osc off", osc_en, 0);
    tick();
    check("R10 irq cleared", irq, 0);
    low_rst = 1'b0;
    ticks(3 + N);
    check("R4 second release", core_rst, 0);
    check("R10 en stays 0", irq, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule